// File: doc/BRIEF.md
# External Bus Address Wait Sequencer

This block runs the address phase of an external memory bus cycle. It can lengthen that phase separately for each of four external memory areas. The design clock runs at twice the bus rate, so every design clock is one half of a bus clock. A bus cycle starts with the high half of state T1. If the target area has its setup wait enabled, one extra high clock follows. Next comes the low half of T1. If the hold wait is enabled, one extra low clock follows. The cycle then ends with a fixed two-clock T2 data phase.

A 16-bit configuration word holds one setup-enable bit and one hold-enable bit for each area. It is written and read as a whole word. Accesses that the upstream address decoder flags as internal (on-chip ROM, RAM or peripheral space) always take the minimum length, whatever the configuration holds. The request address and its wait selection are captured when the request is accepted. A configuration write during a cycle therefore only affects later cycles.

Top module: `ext_addr_wait_seq`

## Requirements
- R1: After reset the configuration reads 16'hFFFF, `req_ready` is 1, and `addr_strobe`, `bus_clk` and `done` are 0.
- R2: Bits 15..8 of the configuration always read as 1, whatever value is written to them.
- R3: Bit 2n of the configuration enables the setup wait of area n, and bit 2n+1 enables its hold wait. The area n is taken from address bits [AREA_SHIFT+1:AREA_SHIFT].
- R4: An enabled setup wait makes `bus_clk` stay high for 2 clocks during T1 instead of 1.
- R5: An enabled hold wait adds one low clock to T1. Together with R4, `addr_strobe` stays high for 2 + setup + hold clocks.
- R6: A request with `req_internal` = 1 always gets an `addr_strobe` of exactly 2 clocks, with `bus_clk` high for 1 of them.
- R7: `addr_strobe` stays high without a gap through the whole of T1, including any wait clocks, and is low during T2.
- R8: `done` is a one-clock pulse in the second T2 clock, which is the second clock after `addr_strobe` falls.
- R9: A request is accepted only while `req_ready` is 1. `bus_addr` holds the accepted address for the whole cycle. Requests made while busy are ignored.
- R10: A configuration write during a cycle in progress does not change that cycle's length. It applies to the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_data | output | 16 | Configuration readback |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Access address |
| req_internal | input | 1 | Access targets on-chip space |
| req_ready | output | 1 | Sequencer idle; the request is taken on this edge |
| bus_addr | output | ADDR_W | Latched address of the cycle in progress |
| addr_strobe | output | 1 | High throughout T1 |
| bus_clk | output | 1 | Bus clock level, half-cycle resolution |
| done | output | 1 | Completion pulse at the end of T2 |

## Verification
The hardest case to reach is a configuration write that lands after a request has been accepted but before that cycle has finished. Only in that case does the difference between the captured wait selection and the live register show up at the ports. The driver issues the write on the clock right after acceptance. It keeps the expected length based on the configuration as it stood at acceptance, and then checks that the following request uses the new value. Each area is also visited under all four setup/hold settings, with the other areas set to the complementary bits, so that a mistake in area decode changes the measured T1 length.

// File: rtl/addr_wait_pkg.sv
package addr_wait_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_T1H   = 3'd1,
    PH_T1H_X = 3'd2,
    PH_T1L   = 3'd3,
    PH_T1L_X = 3'd4,
    PH_T2H   = 3'd5,
    PH_T2L   = 3'd6
  } phase_e;

  typedef struct packed {
    logic hold;
    logic setup;
  } wait_sel_t;
endpackage

// File: rtl/addr_wait_cfg.sv
module addr_wait_cfg #(
  parameter int NUM_AREAS = 4,
  parameter int CFG_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CFG_W-1:0]     wr_data,
  output logic [CFG_W-1:0]     rd_data,
  output logic [NUM_AREAS-1:0] setup_en,
  output logic [NUM_AREAS-1:0] hold_en
);
  localparam int EN_W  = 2 * NUM_AREAS;
  localparam int PAD_W = CFG_W - EN_W;

  logic [EN_W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '1;
    else if (wr_en) en_q <= wr_data[EN_W-1:0];
  end

  assign rd_data = {{PAD_W{1'b1}}, en_q};

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
    assign setup_en[a] = en_q[2*a];
    assign hold_en[a]  = en_q[2*a+1];
  end

  assert_wr_takes_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[EN_W-1:0] == $past(wr_data[EN_W-1:0])));
  assert_no_wr_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/addr_area_decode.sv
module addr_area_decode
  import addr_wait_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int AREA_SHIFT = 20,
  parameter int NUM_AREAS  = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 internal_hit,
  input  logic [NUM_AREAS-1:0] setup_en,
  input  logic [NUM_AREAS-1:0] hold_en,
  output wait_sel_t            sel
);
  localparam int AREA_W = $clog2(NUM_AREAS);

  logic [AREA_W-1:0] area_idx;

  assign area_idx  = addr[AREA_SHIFT +: AREA_W];
  assign sel.setup = !internal_hit && setup_en[area_idx];
  assign sel.hold  = !internal_hit && hold_en[area_idx];

  always_comb begin
    if (internal_hit) assert_internal_nowait_R6: assert (sel == '0);
  end
endmodule

// File: rtl/addr_phase_fsm.sv
module addr_phase_fsm
  import addr_wait_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  wait_sel_t         sel,
  output logic              req_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              addr_strobe,
  output logic              bus_clk,
  output logic              done
);
  phase_e    ph_q, ph_d;
  wait_sel_t lat_q;
  logic      accept;
  logic [2:0] run_q;

  assign accept = req_ready && req_valid;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (req_valid) ph_d = PH_T1H;
      PH_T1H:   ph_d = lat_q.setup ? PH_T1H_X : PH_T1L;
      PH_T1H_X: ph_d = PH_T1L;
      PH_T1L:   ph_d = lat_q.hold ? PH_T1L_X : PH_T2H;
      PH_T1L_X: ph_d = PH_T2H;
      PH_T2H:   ph_d = PH_T2L;
      PH_T2L:   ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_IDLE;
      lat_q       <= '0;
      bus_addr    <= '0;
      req_ready   <= 1'b1;
      addr_strobe <= 1'b0;
      bus_clk     <= 1'b0;
      done        <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        lat_q    <= sel;
        bus_addr <= req_addr;
      end
      req_ready   <= (ph_d == PH_IDLE);
      addr_strobe <= (ph_d == PH_T1H) || (ph_d == PH_T1H_X) ||
                     (ph_d == PH_T1L) || (ph_d == PH_T1L_X);
      bus_clk     <= (ph_d == PH_T1H) || (ph_d == PH_T1H_X) || (ph_d == PH_T2H);
      done        <= (ph_d == PH_T2L);
    end
  end

  // length of the current strobe run, used by the checks below
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (addr_strobe) run_q <= run_q + 3'd1;
    else run_q <= '0;
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_t2_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!$past(addr_strobe) && $past(addr_strobe, 2)));
  assert_strobe_max_R5: assert property (@(posedge clk) disable iff (rst)
    run_q <= 3'd4);
  assert_setup_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && run_q == 3'd1) |-> (bus_clk == lat_q.setup));
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(bus_addr));
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |-> !req_ready);
  assert_sel_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(lat_q));
endmodule

// File: rtl/ext_addr_wait_seq.sv
module ext_addr_wait_seq
  import addr_wait_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int AREA_SHIFT = 20,
  parameter int NUM_AREAS  = 4,
  parameter int CFG_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_rd_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_internal,
  output logic              req_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              addr_strobe,
  output logic              bus_clk,
  output logic              done
);
  logic [NUM_AREAS-1:0] setup_en;
  logic [NUM_AREAS-1:0] hold_en;
  wait_sel_t            sel;

  addr_wait_cfg #(.NUM_AREAS(NUM_AREAS), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .setup_en(setup_en), .hold_en(hold_en)
  );

  addr_area_decode #(.ADDR_W(ADDR_W), .AREA_SHIFT(AREA_SHIFT), .NUM_AREAS(NUM_AREAS)) u_dec (
    .addr(req_addr), .internal_hit(req_internal),
    .setup_en(setup_en), .hold_en(hold_en), .sel(sel)
  );

  addr_phase_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .sel(sel),
    .req_ready(req_ready), .bus_addr(bus_addr), .addr_strobe(addr_strobe),
    .bus_clk(bus_clk), .done(done)
  );
endmodule

// File: tb/ext_addr_wait_seq_bench.sv
module ext_addr_wait_seq_bench;
  localparam int ADDR_W = 24;
  localparam int AREA_SHIFT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_internal = 1'b0;
  logic req_ready, addr_strobe, bus_clk, done;
  logic [ADDR_W-1:0] bus_addr;

  int errors = 0;
  int checks = 0;
  logic [7:0] mirror = 8'hFF;

  typedef struct {
    int strobe_len;
    int high_len;
    logic [ADDR_W-1:0] addr;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  ext_addr_wait_seq #(.ADDR_W(ADDR_W), .AREA_SHIFT(AREA_SHIFT)) u_ext_addr_wait_seq (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .req_valid(req_valid), .req_addr(req_addr),
    .req_internal(req_internal), .req_ready(req_ready), .bus_addr(bus_addr),
    .addr_strobe(addr_strobe), .bus_clk(bus_clk), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    mirror = v[7:0];
  endtask

  // driver: issue one access, push expected, optionally write config mid-cycle
  task automatic access(input logic [ADDR_W-1:0] a, input bit internal,
                        input bit mid_wr, input logic [15:0] mid_val);
    exp_t e;
    int area;
    int s, h;
    area = int'(a[AREA_SHIFT +: 2]);
    s = (!internal && mirror[2*area]) ? 1 : 0;
    h = (!internal && mirror[2*area+1]) ? 1 : 0;
    e.strobe_len = 2 + s + h;
    e.high_len = 1 + s;
    e.addr = a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(e);
    req_valid = 1'b1;
    req_addr = a;
    req_internal = internal;
    @(negedge clk);
    req_valid = 1'b0;
    if (mid_wr) begin
      cfg_wr_en = 1'b1;
      cfg_wr_data = mid_val;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      mirror = mid_val[7:0];
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor
  int st_cnt = 0, hi_cnt = 0, since_fall = 0;
  bit prev_strobe = 0, addr_bad = 0, ready_bad = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (addr_strobe) begin
        st_cnt++;
        if (bus_clk) hi_cnt++;
        if (exp_q.size() != 0 && bus_addr != exp_q[0].addr) addr_bad = 1;
        if (req_ready) ready_bad = 1;
        if (prev_strobe == 0 && st_cnt > 1) addr_bad = 1;
        since_fall = 0;
      end else if (prev_strobe) since_fall = 1;
      else if (since_fall != 0) since_fall++;
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(st_cnt == e.strobe_len, "R5 strobe length", st_cnt, e.strobe_len);
          check(hi_cnt == e.high_len, "R4 T1 high length", hi_cnt, e.high_len);
          check(since_fall == 2, "R8 done position", since_fall, 2);
          check(!addr_bad, "R9/R7 bus_addr held, strobe contiguous", int'(bus_addr), int'(e.addr));
          check(!ready_bad, "R9 ready low while busy", 1, 0);
        end
        st_cnt = 0; hi_cnt = 0; since_fall = 0; addr_bad = 0; ready_bad = 0;
      end
      prev_strobe = addr_strobe;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cfg_rd_data == 16'hFFFF, "R1 cfg reset", cfg_rd_data, 16'hFFFF);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(!addr_strobe && !bus_clk && !done, "R1 outputs idle", {addr_strobe, bus_clk, done}, 0);
    // R2 upper byte forced to ones
    write_cfg(16'h0000);
    check(cfg_rd_data == 16'hFF00, "R2 upper ones", cfg_rd_data, 16'hFF00);
    write_cfg(16'h00A5);
    check(cfg_rd_data == 16'hFFA5, "R3 low byte readback", cfg_rd_data, 16'hFFA5);
    // default all-waits path after fresh write of ones
    write_cfg(16'hFFFF);
    access(24'h000123, 0, 0, '0);
    // R3/R4/R5/R6: each area under every setup/hold pair
    for (int a = 0; a < 4; a++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] c2;
        logic [7:0] v;
        c2 = 2'(c);
        v = {4{~c2}};
        v[2*a +: 2] = c2;
        write_cfg({8'h00, v});
        access((24'(a) << AREA_SHIFT) | 24'(16 * c + a), 0, 0, '0);
        access((24'(a) << AREA_SHIFT) | 24'h0F00, 1, 0, '0); // R6 internal
      end
    end
    // upper address bits must not affect area (R3)
    write_cfg(16'h0003);
    access(24'hC00010, 0, 0, '0);
    // R10 mid-cycle write
    write_cfg(16'h00FF);
    access(24'h200040, 0, 1, 16'h0000);
    access(24'h200044, 0, 0, '0);
    // R9 request while busy is ignored
    write_cfg(16'h00FF);
    fork
      access(24'h300100, 0, 0, '0);
      begin
        repeat (2) @(negedge clk);
        req_valid = 1'b1;
        req_addr = 24'h100200;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (4) @(negedge clk);
    check(!addr_strobe && req_ready, "R9 busy request ignored", addr_strobe, 0);
    check(exp_q.size() == 0, "R9 no stray cycle", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule